// File: doc/BRIEF.md
# I2C Register Port with FIFO Backpressure

This block is the slave side of an I2C bus that lets a host reach a small internal register file. It watches an oversampled SDA/SCL pair and finds START and STOP conditions. It checks a 7-bit device address, takes a sub-address byte that selects a register, and then either hands written bytes to a simple register bus or fetches bytes from it and shifts them out. SDA is driven open-drain: the block only ever pulls the line low, through an output enable.

One register index stands for the data port of a transmit FIFO that lives outside the block. When the host writes to that index while the FIFO reports full, the block answers with a NACK and drops the byte. Flow control therefore rides on the bus itself. Bursts written to that index stay on it, so a stream of bytes fills the FIFO. Other registers are walked through in order. The system clock must run at 16 times the SCL rate or faster.

Top module: `i2c_reg_port`

## Requirements
- R1: A START condition (SDA falls while SCL is high) restarts address reception at any point, including a repeated START in the middle of a transaction. A STOP condition (SDA rises while SCL is high) returns the port to idle, so bytes clocked after it without a new START get no ACK.
- R2: In the first byte after a START, bits 7..1 are the device address, sent MSB first, and bit 0 is the direction (1 = read). On a match with SLAVE_ADDR, the port pulls SDA low for the ninth SCL clock (ACK). On a mismatch it leaves SDA released, gives no ACK, and issues no strobes until the next START or STOP.
- R3: In a write transaction, the byte after the address is the sub-address. It is always ACKed, and its low ADDR_W bits load regAddr.
- R4: Each later byte of a write is shifted in MSB first, ACKed, and presented on regWdata with a one-cycle regWe pulse. The pulse is high right after the third rising clk edge that follows the SCL rise of the byte's eighth bit: two synchronizer stages plus one edge-detect cycle.
- R5: A data byte whose target regAddr equals FIFO_REG, arriving while fifoFull is high, gets a NACK (SDA left high in the ninth clock). It produces no regWe and is discarded. Bytes that arrive after fifoFull falls are ACKed again.
- R6: After every byte written or read, regAddr advances by one, modulo 2^ADDR_W. When regAddr equals FIFO_REG it holds instead.
- R7: After a START and an address byte with bit 0 = 1 that is ACKed, regRe pulses for one clock while regRdata is captured for the current regAddr. The byte is shifted out MSB first, and SDA changes only while SCL is low.
- R8: A master ACK (SDA low in the ninth clock of a read byte) makes the port load and send the next register. A master NACK makes it release SDA and issue no further regRe until the next START.
- R9: During reset, and after reset before any bus traffic, sdaOe, regWe and regRe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| regAddr | output | ADDR_W | Current register index |
| regWdata | output | 8 | Byte being written |
| regWe | output | 1 | One-cycle write strobe |
| regRe | output | 1 | One-cycle read strobe; regRdata captured in the same cycle |
| regRdata | input | 8 | Contents of the register at regAddr |
| fifoFull | input | 1 | Transmit FIFO has no room |

## Verification
The bench builds the port with ADDR_W = 4, FIFO_REG = 2 and SLAVE_ADDR = 7'h3C, and models a FIFO that is full after three bytes. With sixteen registers, a burst that starts at index 15 wraps to 0 in two bytes. Because the FIFO index is not 0, the wrap and the hold on the FIFO index are told apart, and a three-entry FIFO reaches the NACK case within one short burst. SCL runs at 40 system clocks per bit, well above the 16x floor, so the latency of the strobe can be checked to the exact cycle.

// File: rtl/i2c_reg_port_pkg.sv
package i2c_reg_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKWAIT,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_IGNORE
  } ctrlState_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftRx;
    logic latchSub;
    logic wrData;
    logic loadTx;
    logic shiftTx;
  } dpCmd_t;

  // synchronized bus view from datapath to control
  typedef struct packed {
    logic sclS;
    logic sdaS;
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } busEvt_t;

endpackage

// File: rtl/i2c_reg_port_dp.sv
module i2c_reg_port_dp
  import i2c_reg_port_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int FIFO_REG    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  output busEvt_t           evt,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic              isFifo,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  output logic              regWe,
  input  logic [7:0]        regRdata
);

  localparam logic [ADDR_W-1:0] FIFO_IDX = ADDR_W'(FIFO_REG);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclD, sdaD;
  logic [7:0]             rxShift, txShift;
  logic                   incAddr;

  // synchronizer chains, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclPipe[SYNC_STAGES-1];
      sdaD    <= sdaPipe[SYNC_STAGES-1];
    end
  end

  always_comb begin
    evt.sclS     = sclPipe[SYNC_STAGES-1];
    evt.sdaS     = sdaPipe[SYNC_STAGES-1];
    evt.sclRise  = evt.sclS & ~sclD;
    evt.sclFall  = ~evt.sclS & sclD;
    evt.startDet = evt.sclS & sclD & sdaD & ~evt.sdaS;
    evt.stopDet  = evt.sclS & sclD & ~sdaD & evt.sdaS;
  end

  assign rxByte  = {rxShift[6:0], evt.sdaS};
  assign txMsb   = txShift[7];
  assign isFifo  = (regAddr == FIFO_IDX);
  assign incAddr = regWe | cmd.loadTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '1;
      regAddr  <= '0;
      regWdata <= '0;
      regWe    <= 1'b0;
    end else begin
      if (cmd.shiftRx) rxShift <= rxByte;
      if (cmd.latchSub)            regAddr <= rxByte[ADDR_W-1:0];
      else if (incAddr && !isFifo) regAddr <= regAddr + 1'b1;
      regWe <= cmd.wrData;
      if (cmd.wrData) regWdata <= rxByte;
      if (cmd.loadTx)       txShift <= regRdata;
      else if (cmd.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/i2c_reg_port_ctrl.sv
module i2c_reg_port_ctrl
  import i2c_reg_port_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h3C
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       isFifo,
  input  logic       fifoFull,
  output dpCmd_t     cmd,
  output logic       sdaOe,
  output logic       regRe
);

  ctrlState_e state;
  phase_e     phase;
  logic [3:0] bitCnt;
  logic       ackBit, rdMode, mackNack;
  logic       byteIn, addrHit, dataOk;

  always_comb begin
    byteIn  = (state == ST_RECV) && evt.sclRise && (bitCnt == 4'd7);
    addrHit = (rxByte[7:1] == SLAVE_ADDR);
    dataOk  = !(isFifo && fifoFull);

    cmd          = '0;
    cmd.shiftRx  = (state == ST_RECV) && evt.sclRise;
    cmd.latchSub = byteIn && (phase == PH_SUB);
    cmd.wrData   = byteIn && (phase == PH_DATA) && dataOk;
    cmd.loadTx   = ((state == ST_ACK) && evt.sclFall && (phase == PH_ADDR) && rdMode)
                || ((state == ST_MACK) && evt.sclFall && !mackNack);
    cmd.shiftTx  = (state == ST_SEND) && evt.sclFall && (bitCnt != 4'd8);

    regRe = cmd.loadTx;
    sdaOe = ((state == ST_ACK) && ackBit) || ((state == ST_SEND) && !txMsb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      ackBit   <= 1'b0;
      rdMode   <= 1'b0;
      mackNack <= 1'b1;
    end else if (evt.startDet) begin
      state  <= ST_RECV;
      phase  <= PH_ADDR;
      bitCnt <= '0;
      ackBit <= 1'b0;
    end else if (evt.stopDet) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: if (evt.sclRise) begin
          bitCnt <= bitCnt + 4'd1;
          if (bitCnt == 4'd7) begin
            bitCnt <= '0;
            unique case (phase)
              PH_ADDR: begin
                if (addrHit) begin
                  ackBit <= 1'b1;
                  rdMode <= rxByte[0];
                  state  <= ST_ACKWAIT;
                end else begin
                  state <= ST_IGNORE;
                end
              end
              PH_SUB: begin
                ackBit <= 1'b1;
                state  <= ST_ACKWAIT;
              end
              default: begin
                ackBit <= dataOk;
                state  <= ST_ACKWAIT;
              end
            endcase
          end
        end
        ST_ACKWAIT: if (evt.sclFall) state <= ST_ACK;
        ST_ACK: if (evt.sclFall) begin
          bitCnt <= '0;
          if (phase == PH_ADDR && rdMode) begin
            state <= ST_SEND;
          end else begin
            state <= ST_RECV;
            if (phase == PH_ADDR)     phase <= PH_SUB;
            else if (phase == PH_SUB) phase <= PH_DATA;
          end
        end
        ST_SEND: begin
          if (evt.sclRise) bitCnt <= bitCnt + 4'd1;
          if (evt.sclFall && bitCnt == 4'd8) state <= ST_MACK;
        end
        ST_MACK: begin
          if (evt.sclRise) mackNack <= evt.sdaS;
          if (evt.sclFall) begin
            bitCnt <= '0;
            state  <= mackNack ? ST_IGNORE : ST_SEND;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_port_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h3C,
  parameter int         ADDR_W      = 4,
  parameter int         FIFO_REG    = 0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [7:0]        regRdata,
  input  logic              fifoFull
);

  dpCmd_t     cmd;
  busEvt_t    evt;
  logic [7:0] rxByte;
  logic       txMsb, isFifo;

  i2c_reg_port_dp #(
    .ADDR_W(ADDR_W), .FIFO_REG(FIFO_REG), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd), .evt(evt),
    .rxByte(rxByte), .txMsb(txMsb), .isFifo(isFifo), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  i2c_reg_port_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .txMsb(txMsb),
    .isFifo(isFifo), .fifoFull(fifoFull), .cmd(cmd), .sdaOe(sdaOe), .regRe(regRe)
  );

endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk #(
  parameter int ADDR_W   = 4,
  parameter int FIFO_REG = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclSync,
  input logic              sdaOe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic              regRe,
  input logic              fifoFull
);

  localparam logic [ADDR_W-1:0] FIFO_IDX = ADDR_W'(FIFO_REG);

  p_full_blocks_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == FIFO_IDX) |-> !$past(fifoFull));

  p_write_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  p_fifo_index_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == FIFO_IDX) |=> (regAddr == FIFO_IDX));

  p_index_steps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr != FIFO_IDX) |=> (regAddr == ADDR_W'($past(regAddr) + 1'b1)));

  p_drive_only_scl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclSync);

  p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));

endmodule

bind i2c_reg_port i2c_reg_port_chk #(.ADDR_W(ADDR_W), .FIFO_REG(FIFO_REG)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(evt.sclS), .sdaOe(sdaOe), .regAddr(regAddr),
  .regWe(regWe), .regRe(regRe), .fifoFull(fifoFull)
);

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;

  localparam int         ADDR_W   = 4;
  localparam int         FIFO_REG = 2;
  localparam logic [6:0] DEV      = 7'h3C;
  localparam int         FIFO_CAP = 3;
  localparam int         Q        = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic              mScl, mSda;
  logic              sdaOe, regWe, regRe, fifoFull;
  logic [ADDR_W-1:0] regAddr;
  logic [7:0]        regWdata, regRdata;
  wire               sdaLine = mSda & ~sdaOe;

  // behavioural register file and FIFO occupancy model
  logic [7:0]  model [16];
  int          fifoPushes, fifoDrained;
  logic [11:0] obsWr[$];
  logic [11:0] expWr[$];
  int          clkCount, weStamp, riseStamp, reCount;
  int          quiet, quietViol, sclViol;
  logic        prevScl, prevOe;
  int          checks, fails, wrSeen;
  bit          timeout;

  assign regRdata = model[regAddr];
  assign fifoFull = (fifoPushes - fifoDrained) >= FIFO_CAP;

  i2c_reg_port #(.SLAVE_ADDR(DEV), .ADDR_W(ADDR_W), .FIFO_REG(FIFO_REG)) u_i2c_reg_port (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata), .fifoFull(fifoFull)
  );

  always @(posedge clk) clkCount++;

  // per-clock monitor
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) model[i] = 8'(16 + i);
      fifoPushes = 0;
      reCount = 0;
      quietViol = 0;
      sclViol = 0;
      prevScl = 1'b1;
      prevOe = 1'b0;
    end else begin
      if (regWe) begin
        weStamp = clkCount;
        obsWr.push_back({regAddr, regWdata});
        model[regAddr] = regWdata;
        if (regAddr == ADDR_W'(FIFO_REG)) fifoPushes++;
      end
      if (regRe) reCount++;
      if (quiet != 0 && sdaOe) quietViol++;
      if (mScl && prevScl && sdaOe && !prevOe) sclViol++;
      prevScl = mScl;
      prevOe = sdaOe;
    end
  end

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    mSda = 1'b1; wq(Q); mScl = 1'b1; wq(Q); mSda = 1'b0; wq(Q); mScl = 1'b0; wq(Q);
  endtask

  task automatic stopC();
    mSda = 1'b0; wq(Q); mScl = 1'b1; wq(Q); mSda = 1'b1; wq(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; wq(Q); mScl = 1'b1;
      if (i == 0) riseStamp = clkCount;
      wq(2 * Q); mScl = 1'b0; wq(Q);
    end
    mSda = 1'b1; wq(Q); mScl = 1'b1; wq(Q); ack = !sdaLine; wq(Q); mScl = 1'b0; wq(Q);
  endtask

  task automatic wrB(input logic [7:0] b, input bit expAck, input string tag);
    bit a;
    writeByte(b, a);
    chk(a == expAck, tag, int'(a), int'(expAck));
  endtask

  task automatic readByte(input bit nack, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); mScl = 1'b1; wq(Q); b = {b[6:0], sdaLine}; wq(Q); mScl = 1'b0; wq(Q);
    end
    mSda = nack; wq(Q); mScl = 1'b1; wq(2 * Q); mScl = 1'b0; wq(Q); mSda = 1'b1;
  endtask

  task automatic checkWrites(input string tag);
    chk(obsWr.size() == expWr.size(), {tag, " write count"}, obsWr.size(), expWr.size());
    for (int i = wrSeen; i < expWr.size() && i < obsWr.size(); i++)
      chk(obsWr[i] == expWr[i], {tag, " write index/data"}, int'(obsWr[i]), int'(expWr[i]));
    wrSeen = expWr.size();
  endtask

  task automatic runTests();
    logic [7:0] b;
    int reBase;
    // R9 reset state
    chk(!sdaOe, "R9 sdaOe in reset", int'(sdaOe), 0);
    chk(!regWe, "R9 regWe in reset", int'(regWe), 0);
    chk(!regRe, "R9 regRe in reset", int'(regRe), 0);
    rstN = 1'b1; wq(5);
    chk(!sdaOe && !regWe && !regRe, "R9 idle after reset", int'({sdaOe, regWe, regRe}), 0);

    // R2 R3 R4 R6: plain register writes
    startC();
    wrB({DEV, 1'b0}, 1'b1, "R2 address match ACK");
    wrB(8'h05, 1'b1, "R3 sub-address ACK");
    expWr.push_back({4'h5, 8'hA1});
    wrB(8'hA1, 1'b1, "R4 data ACK");
    chk(weStamp - riseStamp == 3, "R4 strobe latency", weStamp - riseStamp, 3);
    expWr.push_back({4'h6, 8'hB2});
    wrB(8'hB2, 1'b1, "R6 second byte ACK");
    stopC(); wq(4);
    checkWrites("R6 increment");

    // R5: FIFO backpressure
    startC();
    wrB({DEV, 1'b0}, 1'b1, "R2 address ACK");
    wrB(8'h02, 1'b1, "R3 sub-address to FIFO");
    for (int i = 0; i < 3; i++) begin
      expWr.push_back({4'h2, 8'(8'h30 + i)});
      wrB(8'(8'h30 + i), 1'b1, "R5 ACK while room");
    end
    wrB(8'h3F, 1'b0, "R5 NACK when full");
    chk(fifoPushes == 3, "R5 byte discarded", fifoPushes, 3);
    fifoDrained = fifoPushes;
    expWr.push_back({4'h2, 8'h44});
    wrB(8'h44, 1'b1, "R5 ACK after drain");
    stopC(); wq(4);
    checkWrites("R6 FIFO index held");

    // R6: wrap
    startC();
    wrB({DEV, 1'b0}, 1'b1, "R2 address ACK");
    wrB(8'h0F, 1'b1, "R3 sub-address 15");
    expWr.push_back({4'hF, 8'hC1});
    wrB(8'hC1, 1'b1, "R6 data at 15");
    expWr.push_back({4'h0, 8'hC2});
    wrB(8'hC2, 1'b1, "R6 data after wrap");
    stopC(); wq(4);
    checkWrites("R6 wrap");

    // R7 R8: read with repeated START
    reBase = reCount;
    startC();
    wrB({DEV, 1'b0}, 1'b1, "R2 address ACK");
    wrB(8'h06, 1'b1, "R3 sub-address 6");
    startC();
    wrB({DEV, 1'b1}, 1'b1, "R7 read address ACK");
    readByte(1'b0, b); chk(b == 8'hB2, "R7 first read byte", b, 8'hB2);
    readByte(1'b0, b); chk(b == 8'h17, "R8 next after master ACK", b, 8'h17);
    readByte(1'b1, b); chk(b == 8'h18, "R8 last byte", b, 8'h18);
    chk(reCount - reBase == 3, "R7 read strobes", reCount - reBase, 3);
    quiet = 1;
    readByte(1'b1, b); chk(b == 8'hFF, "R8 SDA released after NACK", b, 8'hFF);
    quiet = 0;
    chk(reCount - reBase == 3, "R8 no strobe after NACK", reCount - reBase, 3);
    stopC(); wq(4);

    // R2: address mismatch
    startC();
    wrB({DEV ^ 7'h01, 1'b0}, 1'b0, "R2 mismatch NACK");
    quiet = 1;
    wrB(8'h03, 1'b0, "R2 ignored byte");
    wrB(8'h77, 1'b0, "R2 ignored byte");
    quiet = 0;
    stopC(); wq(4);
    checkWrites("R2 no write on mismatch");

    // R1: repeated START restarts, STOP ends
    startC();
    wrB({DEV, 1'b0}, 1'b1, "R1 address ACK");
    wrB(8'h03, 1'b1, "R1 sub-address 3");
    startC();
    wrB({DEV, 1'b0}, 1'b1, "R1 address after repeated START");
    wrB(8'h0A, 1'b1, "R1 new sub-address");
    expWr.push_back({4'hA, 8'h5C});
    wrB(8'h5C, 1'b1, "R1 data ACK");
    stopC(); wq(4);
    quiet = 1;
    wrB(8'h99, 1'b0, "R1 no ACK after STOP");
    quiet = 0;
    wq(4);
    checkWrites("R1 writes");
    chk(model[3] == 8'h13, "R1 register 3 untouched", model[3], 8'h13);
    chk(quietViol == 0, "R8 SDA stays released", quietViol, 0);
    chk(sclViol == 0, "R7 drive only while SCL low", sclViol, 0);
  endtask

  initial begin
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1;
    checks = 0; fails = 0; wrSeen = 0; fifoDrained = 0; quiet = 0;
    timeout = 1'b0; weStamp = 0; riseStamp = 0;
    wq(5);
    fork
      runTests();
      begin
        repeat (200000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule